// File: doc/BRIEF.md
# Dithered 8-bit PWM Generator

This block turns an 8-bit duty value into a pulse-width-modulated output whose period is 256 system clocks. It does not compare the duty value against one 256-step ramp. Instead it splits the period into equal sub-periods, so the output repeats at a higher rate. The high-order duty bits set a base high time inside each sub-period. The low-order duty bits add one extra high clock to some of the sub-periods. Two splits are available: four sub-periods of 64 clocks (six base bits plus two dither bits), or two sub-periods of 128 clocks (seven base bits plus one dither bit).

Software or a neighbouring block writes the duty value through a one-cycle write strobe. A shadow stage holds the value until the next full 256-clock period begins, so every period uses one consistent duty value and one split. A pin-enable data bit gates the registered output. When that bit is 0, the output stays low whatever the duty value is.

Top module: `dpwm_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pwm_out` is 0. Reset leaves the active duty at 0 and the split at the four-sub-period setting, and it starts a new 256-clock period on the first edge after release.
- R2: A period lasts 256 clocks, and the period counter wraps from 255 back to 0. Every sub-period starts with the output high for its computed high time H (when H > 0) and ends low for the rest of the sub-period. `pwm_out` is registered, so counter position j shows on the output after the j-th edge of the period.
- R3: With `split_sel` = 0 at the period start, there are four 64-clock sub-periods, i = 0..3. H(i) = duty[7:2] + (i < duty[1:0] ? 1 : 0). For example, duty 100, 101, 102 and 103 give 0, 1, 2 and 3 sub-periods of 26 high clocks, and the others have 25.
- R4: With `split_sel` = 1 at the period start, there are two 128-clock sub-periods, i = 0..1. H(i) = duty[7:1] + (i < duty[0] ? 1 : 0).
- R5: A value written with `duty_we` = 1 becomes active at the start of the next full period and never earlier. A write on the last clock edge of a period counts for the period that follows that edge.
- R6: `split_sel` is sampled only on the edge that ends a period. A change in the middle of a period leaves the current period's waveform unchanged.
- R7: While `pin_en` = 0, `pwm_out` is 0 one clock later. While `pin_en` = 1, the computed waveform appears.
- R8: A duty value of 0 keeps `pwm_out` low for the whole period in either split. Duty 255 in the four-way split gives high times of 64, 64, 64 and 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the period counter advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_we | input | 1 | Write strobe for the duty value, one clock per write |
| duty_wdata | input | 8 | Duty value captured when `duty_we` is 1 |
| split_sel | input | 1 | 0 = four 64-clock sub-periods, 1 = two 128-clock sub-periods |
| pin_en | input | 1 | Output enable data bit; 0 forces the output low |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The duty write path and the period-boundary load can act on the same clock edge. A write issued on the last clock of a period must reach the period that starts at that edge. A write one edge later must wait a whole period. The bench aligns itself to the period boundary by counting edges from reset release. It places a write exactly on the closing edge and another on the first edge of the new period. It then compares each of the two following periods sample by sample against a waveform computed from the requirement formulas. A split change made in the middle of a period is checked the same way, against the next boundary.

// File: rtl/dpwm_pkg.sv
// Package: shared widths and the split-mode encoding for the dithered PWM.
// Assumes an 8-bit duty value and a period of 2**DUTY_W clocks.
package dpwm_pkg;
    localparam int DUTY_W = 8;

    typedef enum logic {
        SPLIT_FOUR = 1'b0,   // four sub-periods, two dither bits
        SPLIT_TWO  = 1'b1    // two sub-periods, one dither bit
    } split_e;
endpackage

// File: rtl/dpwm_timebase.sv
// Module: free-running period counter.
// Counts 0 .. 2**W-1 on every clock and flags the last position of a period,
// which is when the shadow stage loads. Assumes a synchronous active-low reset.
module dpwm_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] pos,
    output logic         last
);
    localparam logic [W-1:0] POS_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Advance the period position, wrapping naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign pos  = cnt_q;
    assign last = (cnt_q == POS_MAX);

    // R2: the last position is followed by position zero.
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == POS_MAX) |=> (cnt_q == '0));

    // R2: every other position is followed by its successor.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != POS_MAX) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/dpwm_shadow.sv
// Module: duty write register plus the per-period active copy.
// The pending value follows each write. The active duty and split load together
// on the period's last edge and see a write made on that same edge.
module dpwm_shadow
    import dpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         split_in,
    input  logic         load,
    output logic [W-1:0] act_duty,
    output split_e       act_split
);
    logic [W-1:0] pend_q;
    logic [W-1:0] pend_next;
    logic [W-1:0] act_q;
    split_e       split_q;

    // Forward a write on this edge into the value being loaded.
    always_comb begin
        pend_next = wr_en ? wr_data : pend_q;
    end

    // Keep the most recent written duty value.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_next;
    end

    // Move duty and split into the active copy at the period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            split_q <= SPLIT_FOUR;
        end else if (load) begin
            act_q   <= pend_next;
            split_q <= split_e'(split_in);
        end
    end

    assign act_duty  = act_q;
    assign act_split = split_q;

    // R5: the active duty never moves away from a period boundary.
    assert_duty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    // R6: the active split never moves away from a period boundary.
    assert_split_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(split_q));

    // R5: a write on the boundary edge is what the new period uses.
    assert_edge_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_en) |=> (act_q == $past(wr_data)));
endmodule

// File: rtl/dpwm_split.sv
// Module: high-time decision for one split variant.
// Uses LO low duty bits as dither and the rest as the base. The period position
// gives the sub-period index (top LO bits) and the offset in it (remaining bits).
module dpwm_split #(
    parameter int W  = 8,
    parameter int LO = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] duty,
    output logic         high
);
    localparam int SUB_W = W - LO;

    logic [SUB_W-1:0] offs;
    logic [LO-1:0]    idx;
    logic [SUB_W-1:0] base;
    logic [LO-1:0]    dith;
    logic             extra;
    logic [SUB_W:0]   thresh;

    // Split position and duty into their fields and form the high time.
    always_comb begin
        offs   = pos[SUB_W-1:0];
        idx    = pos[W-1:SUB_W];
        base   = duty[W-1:LO];
        dith   = duty[LO-1:0];
        extra  = (idx < dith);
        thresh = {1'b0, base} + {{SUB_W{1'b0}}, extra};
        high   = ({1'b0, offs} < thresh);
    end

    // R8: a zero duty value never asks for a high output.
    assert_zero_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !high);

    // R2: a sub-period with a nonzero high time opens high.
    assert_open_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((offs == '0) && ((base != '0) || extra)) |-> high);
endmodule

// File: rtl/dpwm_top.sv
// Module: dithered PWM generator top.
// Combines the timebase, shadow stage and both split variants. It picks one
// variant by the active split and registers the output gated by pin_en.
module dpwm_top
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_we,
    input  logic [DUTY_W-1:0] duty_wdata,
    input  logic              split_sel,
    input  logic              pin_en,
    output logic              pwm_out
);
    localparam int NUM_SPLIT = 2;
    localparam int LO_FOUR   = 2;
    localparam int LO_TWO    = 1;

    logic [DUTY_W-1:0]    pos;
    logic                 last;
    logic [DUTY_W-1:0]    act_duty;
    split_e               act_split;
    logic [NUM_SPLIT-1:0] high_v;
    logic                 out_q;

    dpwm_timebase #(.W(DUTY_W)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .pos  (pos),
        .last (last)
    );

    dpwm_shadow #(.W(DUTY_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (duty_we),
        .wr_data  (duty_wdata),
        .split_in (split_sel),
        .load     (last),
        .act_duty (act_duty),
        .act_split(act_split)
    );

    // One high-time slice for each split variant; index equals split_e value.
    for (genvar g = 0; g < NUM_SPLIT; g++) begin : g_split
        localparam int LO_G = (g == 0) ? LO_FOUR : LO_TWO;
        dpwm_split #(.W(DUTY_W), .LO(LO_G)) u_sp (
            .clk  (clk),
            .rst_n(rst_n),
            .pos  (pos),
            .duty (act_duty),
            .high (high_v[g])
        );
    end

    // Register the selected waveform, forced low while the pin is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= pin_en & high_v[act_split];
    end

    assign pwm_out = out_q;

    // R7: a disabled pin gives a low output on the next clock.
    assert_pin_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> !pwm_out);

    // R1: the output starts low on the first edge after reset.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !pwm_out);
endmodule

// File: tb/dpwm_tb.sv
`timescale 1ns/1ps
module dpwm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = 8'd0;
    logic       split_sel = 1'b0;
    logic       pin_en = 1'b1;
    logic       pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int ecount = 0;
    int hc [4];
    bit done = 0;

    dpwm_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_we   (duty_we),
        .duty_wdata(duty_wdata),
        .split_sel (split_sel),
        .pin_en    (pin_en),
        .pwm_out   (pwm_out)
    );

    always #5 clk = ~clk;

    // Bench-side edge count since reset release, used for period alignment.
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected output at period position j, taken from the R3/R4 formulas.
    function automatic bit model(input int d, input bit two, input bit pen, input int j);
        int lo, sub, base, idx, offs, h;
        lo   = two ? 1 : 2;
        sub  = two ? 128 : 64;
        base = d >> lo;
        idx  = j / sub;
        offs = j % sub;
        h    = base + ((idx < (d % (1 << lo))) ? 1 : 0);
        return pen && (offs < h);
    endfunction

    task automatic write_duty(input int d);
        duty_we    = 1'b1;
        duty_wdata = 8'(d);
        @(negedge clk);
        duty_we    = 1'b0;
    endtask

    task automatic align();
        while (ecount % 256 != 0) @(negedge clk);
    endtask

    // Compare one whole period, starting at an aligned negedge.
    task automatic sample_period(input int d, input bit two, input bit pen, input string req);
        int bad = 0, first_j = -1, act = 0, exp = 0;
        for (int k = 0; k < 4; k++) hc[k] = 0;
        for (int j = 0; j < 256; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (pwm_out) hc[two ? j / 128 : j / 64]++;
            if (pwm_out !== model(d, two, pen, j)) begin
                bad++;
                if (first_j < 0) begin
                    first_j = j;
                    act = int'(pwm_out);
                    exp = int'(model(d, two, pen, j));
                end
            end
        end
        check(bad == 0, $sformatf("%s duty=%0d pos=%0d", req, d, first_j), act, exp);
    endtask

    task automatic apply(input int d, input bit two);
        split_sel = two;
        write_duty(d);
        align();
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        sample_period(0, 1'b0, 1'b1, "R1 R8 reset duty zero");
    endtask

    task automatic t_four_way_R3();
        for (int d = 100; d < 104; d++) begin
            apply(d, 1'b0);
            sample_period(d, 1'b0, 1'b1, "R3 four-way waveform");
            for (int k = 0; k < 4; k++)
                check(hc[k] == ((k < d - 100) ? 26 : 25), $sformatf("R3 sub%0d high count", k), hc[k], (k < d - 100) ? 26 : 25);
        end
    endtask

    task automatic t_full_R8();
        apply(255, 1'b0);
        sample_period(255, 1'b0, 1'b1, "R8 duty 255 four-way");
        check(hc[3] == 63 && hc[0] == 64, "R8 last sub high count", hc[3], 63);
        apply(0, 1'b1);
        sample_period(0, 1'b1, 1'b1, "R8 duty zero two-way");
    endtask

    task automatic t_two_way_R4();
        apply(101, 1'b1);
        sample_period(101, 1'b1, 1'b1, "R4 two-way waveform");
        check(hc[0] == 51 && hc[1] == 50, "R4 first sub extended", hc[0], 51);
        apply(1, 1'b1);
        sample_period(1, 1'b1, 1'b1, "R4 single dither clock");
        apply(200, 1'b1);
        sample_period(200, 1'b1, 1'b1, "R4 even duty");
    endtask

    task automatic t_defer_R5();
        apply(40, 1'b0);
        fork
            sample_period(40, 1'b0, 1'b1, "R5 mid-period write deferred");
            begin repeat (100) @(negedge clk); write_duty(180); end
        join
        sample_period(180, 1'b0, 1'b1, "R5 write applied next period");
        // Write on the closing edge of a period.
        repeat (255) @(negedge clk);
        write_duty(77);
        sample_period(77, 1'b0, 1'b1, "R5 boundary write taken");
        // Write on the first edge of a period.
        fork
            sample_period(77, 1'b0, 1'b1, "R5 write after boundary waits");
            write_duty(150);
        join
        sample_period(150, 1'b0, 1'b1, "R5 late write next period");
    endtask

    task automatic t_split_R6();
        apply(90, 1'b0);
        fork
            sample_period(90, 1'b0, 1'b1, "R6 mid-period split change ignored");
            begin repeat (50) @(negedge clk); split_sel = 1'b1; end
        join
        sample_period(90, 1'b1, 1'b1, "R6 split applied next period");
        split_sel = 1'b0;
        align();
    endtask

    task automatic t_pin_R7();
        apply(255, 1'b0);
        pin_en = 1'b0;
        sample_period(255, 1'b0, 1'b0, "R7 disabled pin low");
        pin_en = 1'b1;
        sample_period(255, 1'b0, 1'b1, "R7 enabled pin restores");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_R1();
        t_four_way_R3();
        t_full_R8();
        t_two_way_R4();
        t_defer_R5();
        t_split_R6();
        t_pin_R7();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule